// File: doc/BRIEF.md
# Configurable Parallel Host Port

This block is a slave parallel port through which an external host and an internal processor pass data by way of one shared data location. Words the host writes collect in an input buffer that the processor later reads. Words the processor writes wait in an output buffer until the host reads them. An input-full flag and an output-empty flag tell each side when it may act. Both flags leave the block as pins and can also be read in a status word.

A control word sets the behaviour of the host side while the block runs. It selects an 8-bit or a 16-bit host bus and one of two strobe schemes. The first scheme uses a separate write strobe and read strobe. The second uses a direction line plus one data strobe, whose active level can be chosen. The control word also sets which byte the byte-select pin addresses, the active level of the flag pins, and whether the output-empty flag is merged onto the input-full pin. A final bit inverts the output-empty bit as the processor sees it in the status word.

The host pins are treated as synchronous to `clk`. Any synchronisation belongs to the level above this block.

Top module: `hostport`

## Requirements
- R1: After reset the control word is zero, input-full is 0 and output-empty is 1. The flag pins then show 0 (input-full) and 1 (output-empty), and the host data bus is not driven.
- R2: A processor write to address 1 loads control bits 6:0. Bits 15:7 read back as 0. Any host strobe edge that falls in the same cycle as a control write is ignored.
- R3: With control bit 1 = 0, pin A low is the write strobe and pin B low is the read strobe. Write data is captured on the leading edge of the write strobe. A read completes on the trailing edge of the read strobe.
- R4: With control bit 1 = 1, pin A gives the direction (1 = read, 0 = write) and pin B is the data strobe. The data strobe is active low when control bit 2 = 0 and active high when control bit 2 = 1.
- R5: With control bit 0 = 1, every host transfer moves a full 16-bit word, and every completed transfer updates the flags.
- R6: With control bit 0 = 0, each transfer moves one byte on data pins 7:0, and the upper pins read 0. The flags change only when the high byte is transferred.
- R7: The addressed byte is the high byte when (byte-select XOR control bit 3) = 1. In 16-bit mode, data pins 7:0 carry the addressed byte and pins 15:8 carry the other byte.
- R8: A completed host word write sets input-full. A processor read of address 0 returns the input buffer and clears input-full.
- R9: A processor write to address 0 loads the output buffer and clears output-empty. A completed host word read sets output-empty.
- R10: Control bit 4 = 1 makes both flag pins active low. Control bit 4 = 0 makes them active high.
- R11: With control bit 5 = 1, the input-full pin shows input-full OR output-empty. The output-empty pin is not affected.
- R12: Address 2 returns the status word: bit 0 is input-full and bit 1 is output-empty. Bit 1 is inverted when control bit 6 = 1.
- R13: When a flag's set event and clear event fall in the same cycle, the newer data wins. A host word write beats a processor data read, so input-full ends at 1. A processor data write beats a completed host read, so output-empty ends at 0.
- R14: The host data bus is driven exactly while the read strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_din | input | 16 | Host data in |
| h_dout | output | 16 | Host data out |
| h_doe | output | 1 | Host data output enable |
| h_bsel | input | 1 | Byte select |
| h_pin_a | input | 1 | Write strobe, or direction line |
| h_pin_b | input | 1 | Read strobe, or data strobe |
| h_ibf_o | output | 1 | Input-full flag pin |
| h_obe_o | output | 1 | Output-empty flag pin |
| p_en | input | 1 | Processor access strobe |
| p_we | input | 1 | Processor write (1) or read (0) |
| p_addr | input | 2 | 0 = data, 1 = control, 2 = status |
| p_wdata | input | 16 | Processor write data |
| p_rdata | output | 16 | Processor read data |

## Verification
The bench goes after four corner cases. The first is the 8-bit half-word boundary: a design that updates a flag on the low byte tells the host or processor too early that the word is complete. The second is the byte-swap mapping in both widths: a wrong XOR puts bytes in the wrong halves, which shows in the value the processor reads back. The third is switching strobe polarity and protocol at run time: a design that reacts to the control change as if it were a strobe edge raises a phantom transfer and sets a flag with no data behind it. The fourth is a set event and a clear event landing in the same cycle: if the wrong one wins, the block loses a word or reports stale data as new.

// File: rtl/hostport_pkg.sv
package hostport_pkg;

  // Control word, bit 6 down to bit 0.
  typedef struct packed {
    logic obe_inv;   // 6: status bit for output-empty is inverted
    logic merge;     // 5: input-full pin also carries output-empty
    logic flag_low;  // 4: flag pins are active low
    logic swap;      // 3: byte-select mapping is swapped
    logic ds_high;   // 2: data strobe is active high (direction protocol only)
    logic rwds;      // 1: direction line plus data strobe protocol
    logic wide;      // 0: 16-bit host transfers
  } cfg_t;

  localparam int CFG_W = 7;

  // Decode one strobe: want_rd=1 gives read-active, 0 gives write-active.
  function automatic logic strobe_on(cfg_t c, logic a, logic b, logic want_rd);
    logic ds;
    if (!c.rwds) return want_rd ? !b : !a;
    ds = c.ds_high ? b : !b;
    return want_rd ? (ds & a) : (ds & !a);
  endfunction

  function automatic logic lane_hi(logic bsel, cfg_t c);
    return bsel ^ c.swap;
  endfunction

  // Flag pins as {obe_pin, ibf_pin}.
  function automatic logic [1:0] flag_pins(cfg_t c, logic ibf, logic obe);
    logic ib;
    ib = c.merge ? (ibf | obe) : ibf;
    return {obe ^ c.flag_low, ib ^ c.flag_low};
  endfunction

endpackage

// File: rtl/hostport_strobe.sv
module hostport_strobe
  import hostport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg,
  input  logic pin_a,
  input  logic pin_b,
  input  logic hold,
  output logic rd_act,
  output logic wr_evt,
  output logic rd_done
);
  logic a_q, b_q;
  logic wr_now, wr_prev, rd_prev;

  // Previous pin levels are decoded with the current control word, so a
  // control change with quiet pins never looks like an edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= 1'b1;
      b_q <= 1'b1;
    end else begin
      a_q <= pin_a;
      b_q <= pin_b;
    end
  end

  always_comb begin
    rd_act  = strobe_on(cfg, pin_a, pin_b, 1'b1);
    wr_now  = strobe_on(cfg, pin_a, pin_b, 1'b0);
    rd_prev = strobe_on(cfg, a_q, b_q, 1'b1);
    wr_prev = strobe_on(cfg, a_q, b_q, 1'b0);
    wr_evt  = wr_now & !wr_prev & !hold;
    rd_done = rd_prev & !rd_act & !hold;
  end
endmodule

// File: rtl/hostport_flags.sv
module hostport_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic word_wr,
  input  logic word_rd,
  input  logic p_rd_data,
  input  logic p_wr_data,
  output logic ibf_q,
  output logic obe_q
);
  // The newer data wins when set and clear meet in one cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibf_q <= 1'b0;
      obe_q <= 1'b1;
    end else begin
      if (word_wr)        ibf_q <= 1'b1;
      else if (p_rd_data) ibf_q <= 1'b0;
      if (p_wr_data)      obe_q <= 1'b0;
      else if (word_rd)   obe_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hostport.sv
module hostport
  import hostport_pkg::*;
#(
  parameter int BW = 8,
  parameter int DW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] h_din,
  output logic [DW-1:0] h_dout,
  output logic          h_doe,
  input  logic          h_bsel,
  input  logic          h_pin_a,
  input  logic          h_pin_b,
  output logic          h_ibf_o,
  output logic          h_obe_o,
  input  logic          p_en,
  input  logic          p_we,
  input  logic [1:0]    p_addr,
  input  logic [DW-1:0] p_wdata,
  output logic [DW-1:0] p_rdata
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CFG  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  function automatic logic [DW-1:0] swap_bytes(logic [DW-1:0] w);
    return {w[BW-1:0], w[DW-1:BW]};
  endfunction

  cfg_t          cfg_q;
  logic [DW-1:0] ibuf_q, obuf_q;
  logic          ibf_q, obe_q;

  // Named internal events.
  logic ctrl_wr, p_rd_data, p_wr_data;
  logic wr_evt, rd_done, rd_act, hi;
  logic word_wr, word_rd;

  assign ctrl_wr   = p_en & p_we & (p_addr == A_CFG);
  assign p_wr_data = p_en & p_we & (p_addr == A_DATA);
  assign p_rd_data = p_en & !p_we & (p_addr == A_DATA);
  assign hi        = lane_hi(h_bsel, cfg_q);
  assign word_wr   = wr_evt & (cfg_q.wide | hi);
  assign word_rd   = rd_done & (cfg_q.wide | hi);

  hostport_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q),
    .pin_a(h_pin_a), .pin_b(h_pin_b), .hold(ctrl_wr),
    .rd_act(rd_act), .wr_evt(wr_evt), .rd_done(rd_done)
  );

  hostport_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .word_wr(word_wr), .word_rd(word_rd),
    .p_rd_data(p_rd_data), .p_wr_data(p_wr_data),
    .ibf_q(ibf_q), .obe_q(obe_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (ctrl_wr) cfg_q <= cfg_t'(p_wdata[CFG_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) obuf_q <= '0;
    else if (p_wr_data) obuf_q <= p_wdata;
  end

  // Input buffer: whole word, or one byte lane in narrow mode.
  generate
    genvar g;
    for (g = 0; g < 2; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rst_n) ibuf_q[g*BW +: BW] <= '0;
        else if (wr_evt) begin
          if (cfg_q.wide)
            ibuf_q[g*BW +: BW] <= hi ? swap_bytes(h_din)[g*BW +: BW]
                                     : h_din[g*BW +: BW];
          else if (hi == (g == 1))
            ibuf_q[g*BW +: BW] <= h_din[BW-1:0];
        end
      end
    end
  endgenerate

  always_comb begin
    h_doe = rd_act;
    if (cfg_q.wide) h_dout = hi ? swap_bytes(obuf_q) : obuf_q;
    else            h_dout = {{BW{1'b0}}, hi ? obuf_q[DW-1:BW] : obuf_q[BW-1:0]};
  end

  always_comb begin
    {h_obe_o, h_ibf_o} = flag_pins(cfg_q, ibf_q, obe_q);
  end

  always_comb begin
    p_rdata = '0;
    case (p_addr)
      A_DATA: p_rdata = ibuf_q;
      A_CFG:  p_rdata[CFG_W-1:0] = cfg_q;
      A_STAT: p_rdata[1:0] = {obe_q ^ cfg_q.obe_inv, ibf_q};
      default: p_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hostport_chk.sv
module hostport_chk (
  input logic clk,
  input logic rst_n,
  input logic word_wr,
  input logic word_rd,
  input logic p_rd_data,
  input logic p_wr_data,
  input logic ibf_q,
  input logic obe_q,
  input logic wr_evt,
  input logic rd_done,
  input logic ctrl_wr
);
  assert_ibf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr |=> ibf_q);
  assert_ibf_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rd_data && !word_wr) |=> !ibf_q);
  assert_obe_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    p_wr_data |=> !obe_q);
  assert_obe_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rd && !p_wr_data) |=> obe_q);
  assert_ibf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_wr && !p_rd_data) |=> $stable(ibf_q));
  assert_obe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_rd && !p_wr_data) |=> $stable(obe_q));
  assert_cfg_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |-> (!wr_evt && !rd_done));
  assert_new_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rd && p_wr_data) |=> !obe_q);
endmodule

bind hostport hostport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .word_wr(word_wr), .word_rd(word_rd),
  .p_rd_data(p_rd_data), .p_wr_data(p_wr_data), .ibf_q(ibf_q),
  .obe_q(obe_q), .wr_evt(wr_evt), .rd_done(rd_done), .ctrl_wr(ctrl_wr)
);

// File: tb/hostport_tb_top.sv
module hostport_tb_top;
  logic clk = 0, rst_n = 0;
  logic [15:0] h_din = 0, h_dout, p_wdata = 0, p_rdata;
  logic h_doe, h_bsel = 0, h_pin_a = 1, h_pin_b = 1, h_ibf_o, h_obe_o;
  logic p_en = 0, p_we = 0;
  logic [1:0] p_addr = 0;

  int checks = 0, errors = 0;
  bit cmp_on = 0;
  logic [6:0] m_cfg = 0;
  bit m_ibf = 0, m_obe = 1;
  logic [15:0] m_ibuf = 0, m_obuf = 0;

  always #4 clk = ~clk;  // 125 MHz

  hostport dut_i (.*);

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit hib(bit b); return b ^ m_cfg[3]; endfunction
  function automatic logic [15:0] sw(logic [15:0] w); return {w[7:0], w[15:8]}; endfunction
  function automatic bit ds_on(logic [6:0] c); return c[2] ? 1'b1 : 1'b0; endfunction
  function automatic bit idle_b(logic [6:0] c); return (c[1] && c[2]) ? 1'b0 : 1'b1; endfunction

  // Expected flag pins from the model: R10, R11.
  always @(negedge clk) if (cmp_on) begin
    bit ib, ob;
    #2;
    ib = (m_cfg[5] ? (m_ibf | m_obe) : m_ibf) ^ m_cfg[4];
    ob = m_obe ^ m_cfg[4];
    chk(h_ibf_o == ib, "R10/R11 ibf pin", {15'b0, h_ibf_o}, {15'b0, ib});
    chk(h_obe_o == ob, "R10 obe pin", {15'b0, h_obe_o}, {15'b0, ob});
  end

  task automatic set_cfg(logic [15:0] v);
    p_en = 1; p_we = 1; p_addr = 1; p_wdata = v;
    h_pin_a = 1; h_pin_b = idle_b(v[6:0]);
    @(posedge clk); m_cfg = v[6:0];
    @(negedge clk); p_en = 0;
  endtask

  task automatic proc_wr(logic [15:0] d);
    p_en = 1; p_we = 1; p_addr = 0; p_wdata = d;
    @(posedge clk); m_obuf = d; m_obe = 0;
    @(negedge clk); p_en = 0;
  endtask

  task automatic proc_rd(logic [1:0] a, string req);
    logic [15:0] e;
    p_en = 1; p_we = 0; p_addr = a;
    #1;
    e = (a == 0) ? m_ibuf : (a == 1) ? {9'b0, m_cfg} :
        {14'b0, m_obe ^ m_cfg[6], m_ibf};
    chk(p_rdata == e, req, p_rdata, e);
    @(posedge clk); if (a == 0) m_ibf = 0;
    @(negedge clk); p_en = 0;
  endtask

  task automatic host_wr(bit b, logic [15:0] d);
    h_bsel = b; h_din = d; h_pin_a = 0;
    h_pin_b = m_cfg[1] ? ds_on(m_cfg) : 1'b1;
    @(posedge clk);
    if (m_cfg[0]) begin m_ibuf = hib(b) ? sw(d) : d; m_ibf = 1; end
    else if (hib(b)) begin m_ibuf[15:8] = d[7:0]; m_ibf = 1; end
    else m_ibuf[7:0] = d[7:0];
    @(negedge clk); h_pin_a = 1; h_pin_b = idle_b(m_cfg);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic host_rd(bit b, string req, bit also_pwr = 0);
    logic [15:0] e;
    h_bsel = b; h_pin_a = 1;
    h_pin_b = m_cfg[1] ? ds_on(m_cfg) : 1'b0;
    #2;
    e = m_cfg[0] ? (hib(b) ? sw(m_obuf) : m_obuf)
                 : {8'h00, hib(b) ? m_obuf[15:8] : m_obuf[7:0]};
    chk(h_doe == 1, "R14 oe during read", {15'b0, h_doe}, 16'd1);
    chk(h_dout == e, req, h_dout, e);
    @(posedge clk); @(negedge clk);
    h_pin_b = idle_b(m_cfg);
    if (also_pwr) begin p_en = 1; p_we = 1; p_addr = 0; p_wdata = 16'h7E57; end
    #2;
    chk(h_doe == 0, "R14 oe after read", {15'b0, h_doe}, 16'd0);
    @(posedge clk);
    if (m_cfg[0] || hib(b)) m_obe = 1;
    if (also_pwr) begin m_obe = 0; m_obuf = 16'h7E57; end
    @(negedge clk); p_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; cmp_on = 1;
    @(negedge clk);
    // R1 reset state
    chk(h_ibf_o == 0 && h_obe_o == 1, "R1 flag pins", {14'b0, h_obe_o, h_ibf_o}, 16'h2);
    chk(h_doe == 0, "R1 bus idle", {15'b0, h_doe}, 16'h0);
    proc_rd(2, "R1 status after reset");
    proc_rd(1, "R1 control after reset");
    // R2 readback with reserved bits
    set_cfg(16'hFFFF); proc_rd(1, "R2 control readback");
    // R3 R5 R8 separate strobes, 16-bit
    set_cfg(16'h0001);
    host_wr(0, 16'hA55A); proc_rd(2, "R8 ibf set");
    proc_rd(0, "R3 R8 word write"); proc_rd(2, "R8 ibf cleared");
    proc_wr(16'h1234); proc_rd(2, "R9 obe cleared");
    host_rd(0, "R3 R5 word read"); proc_rd(2, "R9 obe set");
    // R7 swapped in 16-bit
    set_cfg(16'h0009);
    host_wr(0, 16'hBEEF); proc_rd(0, "R7 wide swap write");
    proc_wr(16'h5678); host_rd(0, "R7 wide swap read");
    host_wr(1, 16'hC0DE); proc_rd(0, "R7 wide normal bsel1");
    // R6 8-bit halves
    set_cfg(16'h0000);
    host_wr(0, 16'hFF11); proc_rd(2, "R6 low byte keeps ibf");
    host_wr(1, 16'h0022); proc_rd(2, "R6 high byte sets ibf");
    proc_rd(0, "R6 assembled word");
    proc_wr(16'hCAFE);
    host_rd(0, "R6 low byte read"); proc_rd(2, "R6 low read keeps obe");
    host_rd(1, "R6 high byte read"); proc_rd(2, "R6 high read sets obe");
    // R7 swap in 8-bit
    set_cfg(16'h0008);
    host_wr(1, 16'h0033); host_wr(0, 16'h0044); proc_rd(0, "R7 narrow swap");
    // R4 direction plus strobe, both polarities
    set_cfg(16'h0003);
    host_wr(0, 16'h1357); proc_rd(0, "R4 ds low write");
    proc_wr(16'h2468); host_rd(0, "R4 ds low read");
    set_cfg(16'h0007);
    host_wr(0, 16'h9ABC); proc_rd(0, "R4 ds high write");
    proc_wr(16'hDEF0); host_rd(0, "R4 ds high read");
    // R10 R11 R12 pin and status options (pins checked every clock)
    set_cfg(16'h0013); proc_wr(16'h0101); host_wr(0, 16'h0202);
    set_cfg(16'h0023); proc_rd(2, "R11 merge status");
    proc_rd(0, "R11 drain");
    set_cfg(16'h0033); host_rd(0, "R11 read");
    set_cfg(16'h0041); proc_rd(2, "R12 obe inverted");
    // R2 strobe edge during a control write is ignored
    set_cfg(16'h0001);
    p_en = 1; p_we = 1; p_addr = 1; p_wdata = 16'h0001; h_pin_a = 0; h_din = 16'h6666;
    @(posedge clk); @(negedge clk); p_en = 0; h_pin_a = 1;
    @(posedge clk); @(negedge clk);
    proc_rd(2, "R2 edge ignored on control write");
    // R13 host word write meets processor data read
    host_wr(0, 16'h1111);
    p_en = 1; p_we = 0; p_addr = 0; h_din = 16'h2222; h_bsel = 0; h_pin_a = 0;
    @(posedge clk); m_ibuf = 16'h2222; m_ibf = 1;
    @(negedge clk); p_en = 0; h_pin_a = 1;
    @(posedge clk); @(negedge clk);
    proc_rd(2, "R13 ibf stays set");
    proc_rd(0, "R13 newest word kept");
    // R13 completed host read meets processor data write
    proc_wr(16'h3333);
    host_rd(0, "R13 read data", 1);
    proc_rd(2, "R13 obe stays clear");
    host_rd(0, "R13 newest output word");
    repeat (2) @(negedge clk);
    cmp_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule